// File: doc/BRIEF.md
# Retimed Radix-4 Division Recurrence

This block is the iterative core of a digit-recurrence divider for normalized significands. A one-cycle start strobe loads a dividend and a divisor, both fractions in [1/2, 1). From then on the block produces one radix-4 quotient digit from the set {-2, -1, 0, +1, +2} on every clock cycle. Each step computes the next partial residual as four times the current one minus the selected multiple of the divisor. When the last digit has been used, the block raises a one-cycle done flag and presents the final residual as a two's-complement integer. An external unit turns the digit stream into a quotient and rounds it.

Digit selection is retimed. The digit for the next step is chosen at the end of the current step from the freshly computed residual and is held in a register, so the divisor-multiple mux sits outside the loop. Only the top `TOP_W` residual bits feed selection, and they are stored already assimilated. The low part stays redundant: every pair of bits keeps two sum bits and one carry bit, and the even bit's carry ripples into the odd bit inside the adder. With default parameters the residual is 56 bits, split into an 8-bit assimilated top and a 48-bit redundant low part. The block retires 27 digits, which gives 54 quotient bits.

Top module: `srt4_recurrence`

## Requirements
- R1: A start accepted while idle makes `digit_vld_o` high for exactly ITERS = (FRAC_W+2)/2 consecutive cycles, beginning with the cycle after the accepting edge. `done_o` is then high for exactly one cycle, in the cycle right after the last valid digit.
- R2: The bits of `digit_o` are [2] sign, [1] magnitude 2 and [0] magnitude 1. Both magnitude bits are never set together, and the sign bit is never set with a zero magnitude.
- R3: With X = dividend, D = divisor (integers of FRAC_W bits), Q = the sum of digit_j·4^(ITERS-j) and W = `residual_o` read as a signed integer, X·4^ITERS = 4·Q·D + W holds exactly.
- R4: The partial residual stays within ±(2/3)·d after every step, so the final value satisfies 3·|W| ≤ 8·D.
- R5: After correction (Q−1 and W+4D when W < 0), the quotient equals floor(X·4^(ITERS−1)/D) and the corrected W equals 4·(X·4^(ITERS−1) mod D).
- R6: After done, `digit_o` (the last digit) and `residual_o` hold their values until the next accepted start.
- R7: A start while busy is ignored. The operands are captured at the accepted start, so later changes on the operand inputs do not affect the result.
- R8: While reset is applied and after it is released, `digit_vld_o` and `done_o` are low and `residual_o` is zero until the first start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Load the operands and begin a division (ignored while busy) |
| dividend_i | input | FRAC_W | Dividend fraction; MSB set (value in [1/2,1)) |
| divisor_i | input | FRAC_W | Divisor fraction; MSB set (value in [1/2,1)) |
| digit_vld_o | output | 1 | `digit_o` holds the digit used in this step |
| digit_o | output | 3 | Quotient digit {sign, mag2, mag1} |
| done_o | output | 1 | One-cycle pulse after the last step |
| residual_o | output | FRAC_W+3 | Assimilated final residual, signed, unit 2^-(FRAC_W+2) |

## Verification
The assertions check every cycle that the registered digit code is legal and that the assimilated top estimate stays in the window the ±(2/3)·d bound allows. They also check that the step counter advances without a break while busy (so a start in that time has no effect), that the last step ends the run with a single done pulse, and that the residual and digit are frozen while idle. Only the bench scenarios can show that the selection thresholds are right for every divisor interval and that the rebuilt quotient and remainder match integer division. The same holds for the operand capture at start. To show these, the bench runs every dividend against divisors that cover every selection interval and both ends of the divisor range.

// File: rtl/srt4_pkg.sv
package srt4_pkg;

  // Quotient digit: sign plus one-hot magnitude; bit order {neg, two, one}.
  typedef struct packed {
    logic neg;
    logic two;
    logic one;
  } qdig_t;

  // Smallest estimate (in units of 2^-est_frac) from which digit k may be
  // chosen for the divisor interval [1/2 + idx/16, 1/2 + (idx+1)/16).
  // The bound (k - 2/3)*d is taken at the interval end where it is largest.
  function automatic int sel_threshold(int k, int idx, int est_frac);
    int j;
    int num;
    j   = (k > 0) ? idx + 1 : idx;
    num = (3 * k - 2) * (8 + j) * (1 << est_frac);
    if (num >= 0) return (num + 47) / 48;
    else          return -((-num) / 48);
  endfunction

endpackage

// File: rtl/srt4_qsel.sv
module srt4_qsel
  import srt4_pkg::*;
#(
  parameter int EST_W = 8
) (
  input  logic [EST_W-1:0] est_i,
  input  logic [2:0]       dsel_i,
  output qdig_t            q_o
);
  localparam int THR_W = EST_W + 1;
  localparam int EFRAC = EST_W - 3;

  logic signed [THR_W-1:0] thr [4][8];
  logic signed [THR_W-1:0] est_x;
  logic [3:0]              ge;

  for (genvar gk = 0; gk < 4; gk++) begin : g_digit
    for (genvar gi = 0; gi < 8; gi++) begin : g_intv
      assign thr[gk][gi] = THR_W'(sel_threshold(gk - 1, gi, EFRAC));
    end
    assign ge[gk] = (est_x >= thr[gk][dsel_i]);
  end

  assign est_x = THR_W'($signed(est_i));

  always_comb begin
    q_o = '0;
    if (ge[3])      q_o.two = 1'b1;
    else if (ge[2]) q_o.one = 1'b1;
    else if (ge[1]) q_o     = '0;
    else if (ge[0]) begin q_o.neg = 1'b1; q_o.one = 1'b1; end
    else            begin q_o.neg = 1'b1; q_o.two = 1'b1; end
  end

endmodule

// File: rtl/srt4_multgen.sv
module srt4_multgen
  import srt4_pkg::*;
#(
  parameter int FRAC_W = 53,
  parameter int RES_W  = FRAC_W + 3
) (
  input  logic [FRAC_W-1:0] dvs_i,
  input  qdig_t             dig_i,
  output logic [RES_W-1:0]  mult_o,
  output logic              cin_o
);
  logic [RES_W-1:0] mag;
  logic             sub;

  always_comb begin
    if (dig_i.two)      mag = {dvs_i, 3'b000};
    else if (dig_i.one) mag = {1'b0, dvs_i, 2'b00};
    else                mag = '0;
    sub    = (dig_i.one | dig_i.two) & ~dig_i.neg;
    mult_o = sub ? ~mag : mag;
    cin_o  = sub;
  end

endmodule

// File: rtl/srt4_r4csa.sv
module srt4_r4csa #(
  parameter int PAIRS = 24
) (
  input  logic [2*PAIRS-1:0] a_i,
  input  logic [2*PAIRS-1:0] b_i,
  input  logic [PAIRS-1:0]   cin_i,
  output logic [2*PAIRS-1:0] sum_o,
  output logic [PAIRS-1:0]   cout_o
);
  for (genvar gp = 0; gp < PAIRS; gp++) begin : g_pair
    logic a0, a1, b0, b1, c0, kmid;
    assign a0 = a_i[2*gp];
    assign a1 = a_i[2*gp+1];
    assign b0 = b_i[2*gp];
    assign b1 = b_i[2*gp+1];
    assign c0 = cin_i[gp];
    // even bit: full add, carry ripples into the odd bit of the same pair
    assign sum_o[2*gp]   = a0 ^ b0 ^ c0;
    assign kmid          = (a0 & b0) | (a0 & c0) | (b0 & c0);
    assign sum_o[2*gp+1] = a1 ^ b1 ^ kmid;
    assign cout_o[gp]    = (a1 & b1) | (a1 & kmid) | (b1 & kmid);
  end

endmodule

// File: rtl/srt4_recurrence.sv
module srt4_recurrence
  import srt4_pkg::*;
#(
  parameter int FRAC_W = 53,
  parameter int TOP_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [FRAC_W-1:0] dividend_i,
  input  logic [FRAC_W-1:0] divisor_i,
  output logic              digit_vld_o,
  output logic [2:0]        digit_o,
  output logic              done_o,
  output logic [FRAC_W+2:0] residual_o
);
  localparam int RES_W  = FRAC_W + 3;
  localparam int LOW_W  = RES_W - TOP_W;
  localparam int PAIRS  = LOW_W / 2;
  localparam int ITERS  = (FRAC_W + 2) / 2;
  localparam int CNT_W  = $clog2(ITERS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ITERS - 1);
  localparam int EST_HI = ((1 << (TOP_W - 1)) * 2) / 3;
  localparam int EST_LO = -EST_HI - 2;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rsync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  // state
  logic              busy_q, busy_d, done_q, done_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [TOP_W-1:0]  top_q, top_d;
  logic [LOW_W-1:0]  sum_q, sum_d;
  logic [PAIRS-2:0]  car_q, car_d;
  qdig_t             dig_q, dig_d;
  logic [FRAC_W-1:0] dvs_q, dvs_d;

  logic              accept;
  logic [RES_W-1:0]  init_w;
  logic [RES_W-1:0]  mult_w;
  logic              mult_cin;
  logic [LOW_W-1:0]  csa_a, csa_s;
  logic [PAIRS-1:0]  csa_cin, csa_cout;
  logic [TOP_W-1:0]  top_new, sel_est;
  logic [FRAC_W-1:0] sel_dvs;
  qdig_t             sel_q;
  logic [RES_W-1:0]  car_vec;

  assign accept = start_i & ~busy_q;
  assign init_w = RES_W'(dividend_i);   // w[0] = x/4 in the 2^-(FRAC_W+2) grid

  // multiple from the registered digit: outside the selection loop
  srt4_multgen #(.FRAC_W(FRAC_W), .RES_W(RES_W)) u_mult (
    .dvs_i  (dvs_q),
    .dig_i  (dig_q),
    .mult_o (mult_w),
    .cin_o  (mult_cin)
  );

  // low part: 4*S, multiple, shifted pair carries (carry-in of the multiple in slot 0)
  assign csa_a = {sum_q[LOW_W-3:0], 2'b00};

  always_comb begin
    csa_cin    = '0;
    csa_cin[0] = mult_cin;
    for (int i = 2; i < PAIRS; i++) csa_cin[i] = car_q[i-2];
  end

  srt4_r4csa #(.PAIRS(PAIRS)) u_csa (
    .a_i    (csa_a),
    .b_i    (mult_w[LOW_W-1:0]),
    .cin_i  (csa_cin),
    .sum_o  (csa_s),
    .cout_o (csa_cout)
  );

  // top part: assimilated, includes everything crossing the boundary
  assign top_new = (top_q << 2)
                 + TOP_W'(sum_q[LOW_W-1:LOW_W-2])
                 + TOP_W'(car_q[PAIRS-2])
                 + mult_w[RES_W-1:LOW_W]
                 + TOP_W'(csa_cout[PAIRS-1]);

  // retimed selection: next digit chosen from the new top bits
  assign sel_est = accept ? init_w[RES_W-1:LOW_W] : top_new;
  assign sel_dvs = accept ? divisor_i : dvs_q;

  srt4_qsel #(.EST_W(TOP_W)) u_sel (
    .est_i  (sel_est),
    .dsel_i (sel_dvs[FRAC_W-2:FRAC_W-4]),
    .q_o    (sel_q)
  );

  // next state
  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    top_d  = top_q;
    sum_d  = sum_q;
    car_d  = car_q;
    dig_d  = dig_q;
    dvs_d  = dvs_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      top_d  = init_w[RES_W-1:LOW_W];
      sum_d  = init_w[LOW_W-1:0];
      car_d  = '0;
      dig_d  = sel_q;
      dvs_d  = divisor_i;
    end else if (busy_q) begin
      top_d = top_new;
      sum_d = csa_s;
      car_d = csa_cout[PAIRS-2:0];
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        dig_d = sel_q;
      end
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      top_q  <= '0;
      sum_q  <= '0;
      car_q  <= '0;
      dig_q  <= '0;
      dvs_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      top_q  <= top_d;
      sum_q  <= sum_d;
      car_q  <= car_d;
      dig_q  <= dig_d;
      dvs_q  <= dvs_d;
    end
  end

  // output assimilation of the redundant residual
  always_comb begin
    car_vec = '0;
    for (int i = 0; i < PAIRS - 1; i++) car_vec[2*i+2] = car_q[i];
  end

  assign residual_o  = {top_q, sum_q} + car_vec;
  assign digit_vld_o = busy_q;
  assign digit_o     = dig_q;
  assign done_o      = done_q;

  // checks
  assert_digit_code_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(dig_q.one && dig_q.two) && (!dig_q.neg || dig_q.one || dig_q.two));

  assert_estimate_window_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($signed(top_q) >= EST_LO) && ($signed(top_q) <= EST_HI));

  assert_last_step_R1: assert property (@(posedge clk_i) disable iff (!rst_n)
    (busy_q && cnt_q == LAST) |=> (done_q && !busy_q));

  assert_done_single_R1: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_run_unbroken_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (busy_q && cnt_q != LAST) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));

  assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!busy_q && !start_i) |=> ($stable(residual_o) && $stable(digit_o)));

endmodule

// File: tb/sim_srt4_recurrence.sv
`timescale 1ns/1ps
module sim_srt4_recurrence;
  localparam int F  = 9;
  localparam int N  = (F + 2) / 2;
  localparam int RW = F + 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [F-1:0]  dividend, divisor;
  logic          digit_vld, done;
  logic [2:0]    digit;
  logic [RW-1:0] residual;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;   // 125 MHz

  srt4_recurrence #(.FRAC_W(F), .TOP_W(8)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .dividend_i  (dividend),
    .divisor_i   (divisor),
    .digit_vld_o (digit_vld),
    .digit_o     (digit),
    .done_o      (done),
    .residual_o  (residual)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_div(input int x, input int dv, input bit poke);
    longint q = 0;
    longint w, lhs, rhs, num, qc, rc, hold_w;
    int     nd = 0;
    int     val;
    logic [2:0] last_dig = 3'b000;
    @(negedge clk);
    dividend = F'(x);
    divisor  = F'(dv);
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (digit_vld && nd < N + 2) begin
      // R2: {sign, mag2, mag1}
      check(!(digit[1] && digit[0]) && !(digit == 3'b100), "R2", "digit code",
            longint'(digit), 0);
      val = digit[1] ? 2 : (digit[0] ? 1 : 0);
      if (digit[2]) val = -val;
      q = q * 4 + val;
      last_dig = digit;
      nd++;
      if (poke && nd == 2) begin
        // R7: start while busy, with different operands on the inputs
        start    = 1'b1;
        dividend = F'(x ^ 85) | F'(1 << (F - 1));
        divisor  = F'(dv ^ 170) | F'(1 << (F - 1));
      end
      @(negedge clk);
      start = 1'b0;
    end
    check(nd == N, "R1", "digit count", nd, N);
    check(done == 1'b1, "R1", "done after last digit", longint'(done), 1);
    w   = longint'($signed(residual));
    lhs = longint'(x) <<< (2 * N);
    rhs = 4 * q * longint'(dv) + w;
    check(lhs == rhs, poke ? "R7" : "R3", "identity x*4^n", rhs, lhs);
    check(3 * (w < 0 ? -w : w) <= 8 * longint'(dv), "R4", "residual bound", w, 0);
    num = longint'(x) <<< (2 * (N - 1));
    qc  = (w < 0) ? q - 1 : q;
    rc  = (w < 0) ? w + 4 * longint'(dv) : w;
    check(qc == num / longint'(dv), "R5", "quotient", qc, num / longint'(dv));
    check(rc == 4 * (num % longint'(dv)), "R5", "remainder", rc, 4 * (num % longint'(dv)));
    hold_w = w;
    @(negedge clk);
    check(done == 1'b0, "R1", "done width", longint'(done), 0);
    @(negedge clk);
    check(longint'($signed(residual)) == hold_w, "R6", "residual hold",
          longint'($signed(residual)), hold_w);
    check(digit == last_dig, "R6", "digit hold", longint'(digit), longint'(last_dig));
  endtask

  initial begin
    rst_n    = 1'b0;
    start    = 1'b0;
    dividend = '0;
    divisor  = '0;
    repeat (3) @(negedge clk);
    check(!digit_vld && !done, "R8", "outputs in reset", longint'({digit_vld, done}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!digit_vld && !done, "R8", "outputs after release", longint'({digit_vld, done}), 0);
    check(residual == '0, "R8", "residual after release", longint'(residual), 0);

    // all dividends against divisors spanning every selection interval and both ends
    for (int j = 0; j < 32; j++) begin
      for (int i = 0; i < (1 << (F - 1)); i++) begin
        run_div((1 << (F - 1)) + i, (1 << (F - 1)) + j * 8 + (j % 8), 1'b0);
      end
    end
    // starts during a run are ignored and operands are captured at start (R7)
    for (int k = 0; k < 64; k++) begin
      run_div((1 << (F - 1)) + k * 4 + 3, (1 << F) - 1 - k * 3, 1'b1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule